// File: doc/BRIEF.md
# Reduced Legacy DMA Channel Controller

This block is an eight-slot DMA channel controller that uses the register model of the classic PC peripheral DMA engine, but only a trimmed subset of it. Each channel slot keeps a base and a current address and a base and a current word count. It also keeps a mode setting and a mask bit. Each half of the controller (slots 0-3 and slots 4-7) has its own disable bit and its own status byte. Software programs the slots through a small synchronous register port. Devices raise per-channel request lines.

On each grant the controller picks the lowest-numbered eligible channel and presents one transfer to a downstream bus agent: the channel, the current address, a width flag and a memory read or memory write strobe. It holds that transfer until the agent acknowledges it. Each acknowledge advances the address and the count. The last transfer of a run is marked as terminal count. At terminal count the channel either masks itself or reloads its current registers from the base registers. Slots 0-3 move bytes and slots 5-7 move 16-bit words. Slot 4 is reserved as the cascade link and never moves data.

Top module: `ldma_ctrl`

## Requirements
- R1: After reset all eight mask bits are set, both status bytes read 0, both command registers read 0 and `xfer_req` is low.
- R2: Register map, with the half selected by address bit 0:
  - A write to 0x00+n loads both the base and the current address of slot n.
  - A write to 0x08+n loads both the base and the current count of slot n. Reads at these addresses return the current values.
  - 0x10/0x11 is the command register (low/high half).
  - 0x12/0x13 is the mode register. Its data bits 1:0 pick the slot within the half.
  - 0x14/0x15 is the mask register, bits 3:0.
  - 0x16/0x17 is the status register.
- R3: When several channels are eligible at once, the lowest-numbered one is granted first.
- R4: While `xfer_req` is high, `xfer_addr` shows the current address, and the transfer is held until `xfer_ack`. Each acknowledged transfer adds 1 to the current address and subtracts 1 from the current count. `xfer_wide` is high for slots 5-7.
- R5: A transfer made while the current count is 0 is flagged with `xfer_tc`. After it the count reads 0xFFFF, the slot's status bit (bits 3:0, one per slot in the half) is set, and, unless auto-initialization is on, the slot's mask bit is set.
- R6: With mode bit 4 set, terminal count instead reloads the current address and count from the base values and leaves the mask bit clear.
- R7: Mode bits 7:6 = 01 (single) give one transfer per grant, and `xfer_req` drops after each acknowledge. The obsolete values 10 and 11 behave the same way.
- R8: Mode bits 7:6 = 00 (demand) keep the channel granted across acknowledges while its request stays high. The burst ends at terminal count.
- R9: Mode bits 3:2 select the transfer type:
  - 01 raises `xfer_wr`.
  - 10 raises `xfer_rd`.
  - 00 (verify) sequences address and count with neither strobe.
  - 11 never produces a transfer.
- R10: A request on slot 4 never produces a transfer, and its registers are only storage.
- R11: Command bit 2 set disables all channels of that half. The other command bits are ignored, and a read of the command register returns only bit 2.
- R12: A status read with `reg_re` clears that half's terminal-count bits. A terminal count in the same cycle as the read stays set. Status bits 7:4 show the half's raw request lines.
- R13: Mode bit 5 is ignored. Addresses always increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears status on status addresses) |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| dreq | input | 8 | Per-channel transfer requests |
| xfer_req | output | 1 | Transfer presented to the bus agent |
| xfer_ack | input | 1 | Bus agent accepts the presented transfer |
| xfer_ch | output | 3 | Channel of the presented transfer |
| xfer_addr | output | 16 | Current address of the presented transfer |
| xfer_wide | output | 1 | 16-bit transfer |
| xfer_rd | output | 1 | Memory read strobe |
| xfer_wr | output | 1 | Memory write strobe |
| xfer_tc | output | 1 | This transfer reaches terminal count |

## Verification
Two events can land on the same clock edge: terminal count setting a status bit, and a software status read clearing the bits of that half. The bench provokes this on a verify channel. It waits for the falling edge where `xfer_req` is already high, and raises `reg_re` on the status address in the same half-cycle in which its responder raises `xfer_ack`. The test passes if a later plain read still shows the terminal-count bit, and a further strobed read shows it cleared.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  localparam int REGW = 16;

  typedef enum logic [1:0] {
    XT_VERIFY = 2'b00,
    XT_WRITE  = 2'b01,
    XT_READ   = 2'b10,
    XT_BAD    = 2'b11
  } xtype_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       autoinit;
    xtype_e     xtype;
  } mode_t;

  function automatic logic [REGW-1:0] addr_next(input logic [REGW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [REGW-1:0] count_next(input logic [REGW-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic is_last(input logic [REGW-1:0] c);
    return c == '0;
  endfunction

  function automatic logic is_demand(input mode_t m);
    return m.sel == 2'b00;
  endfunction

  // bit 5 (direction) is deliberately dropped
  function automatic mode_t mode_from_byte(input logic [7:0] b);
    mode_t m;
    m.sel      = b[7:6];
    m.autoinit = b[4];
    m.xtype    = xtype_e'(b[3:2]);
    return m;
  endfunction
endpackage

// File: rtl/ldma_chan.sv
module ldma_chan
  import ldma_pkg::*;
#(
  parameter int W = REGW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr_we,
  input  logic         cnt_we,
  input  logic [W-1:0] wdata,
  input  logic         mode_we,
  input  mode_t        mode_in,
  input  logic         step,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] cur_cnt,
  output mode_t        mode_q,
  output logic         tc_hit
);
  logic [W-1:0] base_addr, base_cnt;

  assign tc_hit = step && is_last(cur_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode_q    <= '0;
    end else begin
      if (mode_we) mode_q <= mode_in;
      if (addr_we) begin
        base_addr <= wdata;
        cur_addr  <= wdata;
      end else if (step) begin
        cur_addr <= (tc_hit && mode_q.autoinit) ? base_addr : addr_next(cur_addr);
      end
      if (cnt_we) begin
        base_cnt <= wdata;
        cur_cnt  <= wdata;
      end else if (step) begin
        cur_cnt <= (tc_hit && mode_q.autoinit) ? base_cnt : count_next(cur_cnt);
      end
    end
  end
endmodule

// File: rtl/ldma_arb.sv
module ldma_arb #(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/ldma_seq.sv
module ldma_seq #(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gnt_any,
  input  logic [CHW-1:0] gnt_ch,
  input  logic           xfer_ack,
  input  logic           keep,
  output logic           busy,
  output logic [CHW-1:0] sel_ch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sel_ch <= '0;
    end else if (!busy) begin
      if (gnt_any) begin
        busy   <= 1'b1;
        sel_ch <= gnt_ch;
      end
    end else if (xfer_ack && !keep) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ldma_ctrl.sv
module ldma_ctrl
  import ldma_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int RAW     = 6,
  parameter int CASCADE = 4,
  localparam int CHW    = $clog2(NCH),
  localparam int HALF   = NCH / 2,
  localparam int HW     = $clog2(HALF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [REGW-1:0] reg_wdata,
  output logic [REGW-1:0] reg_rdata,
  input  logic [NCH-1:0]  dreq,
  output logic            xfer_req,
  input  logic            xfer_ack,
  output logic [CHW-1:0]  xfer_ch,
  output logic [REGW-1:0] xfer_addr,
  output logic            xfer_wide,
  output logic            xfer_rd,
  output logic            xfer_wr,
  output logic            xfer_tc
);
  localparam logic [RAW-1:0] A_CMD  = RAW'(6'h10);
  localparam logic [RAW-1:0] A_MODE = RAW'(6'h12);
  localparam logic [RAW-1:0] A_MASK = RAW'(6'h14);
  localparam logic [RAW-1:0] A_STAT = RAW'(6'h16);

  logic [REGW-1:0] cur_addr [NCH];
  logic [REGW-1:0] cur_cnt  [NCH];
  mode_t           mode_q   [NCH];
  logic [NCH-1:0]  tc_hit, step_vec, elig, mask_q, tc_bits, clr_vec;
  logic [1:0]      dis_q;
  logic            gnt_any, keep, busy, sel_single;
  logic [CHW-1:0]  gnt_ch, sel_ch;
  mode_t           mode_wr;
  logic            wr_half;

  assign wr_half = reg_addr[0];
  assign mode_wr = mode_from_byte(reg_wdata[7:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int H = i / HALF;
    logic addr_we, cnt_we, mode_we;
    assign addr_we = reg_we && reg_addr == RAW'(i);
    assign cnt_we  = reg_we && reg_addr == RAW'(NCH + i);
    assign mode_we = reg_we && reg_addr == (A_MODE | RAW'(H))
                     && reg_wdata[HW-1:0] == HW'(i % HALF);
    assign step_vec[i] = busy && xfer_ack && sel_ch == CHW'(i);
    assign clr_vec[i]  = reg_re && reg_addr == (A_STAT | RAW'(H));

    if (i == CASCADE) begin : g_casc
      assign elig[i] = 1'b0;
    end else begin : g_norm
      assign elig[i] = dreq[i] && !mask_q[i] && !dis_q[H]
                       && mode_q[i].xtype != XT_BAD;
    end

    ldma_chan #(.W(REGW)) u_chan (
      .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .cnt_we(cnt_we),
      .wdata(reg_wdata), .mode_we(mode_we), .mode_in(mode_wr),
      .step(step_vec[i]), .cur_addr(cur_addr[i]), .cur_cnt(cur_cnt[i]),
      .mode_q(mode_q[i]), .tc_hit(tc_hit[i])
    );
  end

  ldma_arb #(.NCH(NCH)) u_arb (.req(elig), .any(gnt_any), .idx(gnt_ch));

  assign keep = is_demand(mode_q[sel_ch]) && dreq[sel_ch] && elig[sel_ch]
                && !is_last(cur_cnt[sel_ch]);
  assign sel_single = !is_demand(mode_q[sel_ch]);

  ldma_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .gnt_ch(gnt_ch),
    .xfer_ack(xfer_ack), .keep(keep), .busy(busy), .sel_ch(sel_ch)
  );

  // mask, command and status state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      dis_q   <= '0;
      tc_bits <= '0;
    end else begin
      logic [NCH-1:0] m;
      m = mask_q;
      if (reg_we && reg_addr == (A_MASK | RAW'(wr_half)))
        m[wr_half*HALF +: HALF] = reg_wdata[HALF-1:0];
      for (int i = 0; i < NCH; i++)
        if (tc_hit[i] && !mode_q[i].autoinit) m[i] = 1'b1;
      mask_q <= m;
      if (reg_we && reg_addr == (A_CMD | RAW'(wr_half)))
        dis_q[wr_half] <= reg_wdata[2];
      tc_bits <= (tc_bits & ~clr_vec) | tc_hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[RAW-1:CHW])
      0: reg_rdata = cur_addr[reg_addr[CHW-1:0]];
      1: reg_rdata = cur_cnt[reg_addr[CHW-1:0]];
      2: case (reg_addr[2:1])
           2'd0: reg_rdata[2] = dis_q[wr_half];
           2'd2: reg_rdata[HALF-1:0] = mask_q[wr_half*HALF +: HALF];
           2'd3: reg_rdata[2*HALF-1:0] = {dreq[wr_half*HALF +: HALF],
                                          tc_bits[wr_half*HALF +: HALF]};
           default: reg_rdata = '0;
         endcase
      default: reg_rdata = '0;
    endcase
  end

  assign xfer_req  = busy;
  assign xfer_ch   = sel_ch;
  assign xfer_addr = cur_addr[sel_ch];
  assign xfer_wide = sel_ch > CHW'(CASCADE);
  assign xfer_tc   = busy && is_last(cur_cnt[sel_ch]);
  assign xfer_rd   = busy && mode_q[sel_ch].xtype == XT_READ;
  assign xfer_wr   = busy && mode_q[sel_ch].xtype == XT_WRITE;
endmodule

// File: rtl/ldma_ctrl_chk.sv
module ldma_ctrl_chk #(
  parameter int NCH     = 8,
  parameter int CASCADE = 4,
  localparam int CHW    = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           xfer_req,
  input logic           xfer_ack,
  input logic [CHW-1:0] xfer_ch,
  input logic [15:0]    xfer_addr,
  input logic           xfer_rd,
  input logic           xfer_wr,
  input logic [NCH-1:0] tc_hit,
  input logic [NCH-1:0] tc_bits,
  input logic [NCH-1:0] step_vec,
  input logic           sel_single
);
  // R10
  cascade_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_ch != CHW'(CASCADE));
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_rd && xfer_wr));
  // R5
  tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_hit != '0) |=> ((tc_bits & $past(tc_hit)) == $past(tc_hit)));
  // R7
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && sel_single) |=> !xfer_req);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_ch) && $stable(xfer_addr)));
  // R3
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_vec));
endmodule

bind ldma_ctrl ldma_ctrl_chk #(.NCH(NCH), .CASCADE(CASCADE)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .xfer_ch(xfer_ch), .xfer_addr(xfer_addr), .xfer_rd(xfer_rd),
  .xfer_wr(xfer_wr), .tc_hit(tc_hit), .tc_bits(tc_bits),
  .step_vec(step_vec), .sel_single(sel_single)
);

// File: tb/ldma_ctrl_bench.sv
module ldma_ctrl_bench;
  typedef struct packed {
    logic [2:0]  ch;
    logic [15:0] addr;
    logic        wide, tc, rd, wr;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, reg_re = 0;
  logic [5:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  dreq = 0;
  logic        xfer_req, xfer_ack = 0, xfer_wide, xfer_rd, xfer_wr, xfer_tc;
  logic [2:0]  xfer_ch;
  logic [15:0] xfer_addr;

  item_t exp_q[$];
  int compared = 0, mismatched = 0, rises = 0;
  logic req_prev = 0, done = 0;

  always #5 clk = ~clk;

  ldma_ctrl u_ldma_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dreq(dreq), .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_ch(xfer_ch),
    .xfer_addr(xfer_addr), .xfer_wide(xfer_wide), .xfer_rd(xfer_rd),
    .xfer_wr(xfer_wr), .xfer_tc(xfer_tc)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic expect_xfer(input logic [2:0] ch, input logic [15:0] a,
                             input logic tc, input logic rd, input logic wr);
    item_t it;
    it.ch = ch; it.addr = a; it.wide = (ch > 3'd4); it.tc = tc; it.rd = rd; it.wr = wr;
    exp_q.push_back(it);
  endtask

  // monitor: compare each presented transfer and acknowledge it
  always @(negedge clk) begin
    if (xfer_req && !req_prev) rises++;
    req_prev = xfer_req;
    xfer_ack = 1'b0;
    if (rst_n && xfer_req) begin
      item_t got;
      got = {xfer_ch, xfer_addr, xfer_wide, xfer_tc, xfer_rd, xfer_wr};
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R4 unexpected transfer actual=%0h expected=none", got);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (got !== e) begin
          mismatched++;
          $display("FAIL R4 transfer actual=%0h expected=%0h", got, e);
        end
      end
      xfer_ack = 1'b1;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_clear(input logic [5:0] a);
    @(negedge clk); reg_addr = a; reg_re = 1;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h14, v); check("R1 mask lo", v, 16'h000F);
    rd(6'h15, v); check("R1 mask hi", v, 16'h000F);
    rd(6'h16, v); check("R1 status lo", v, 16'h0000);
    rd(6'h10, v); check("R1 command lo", v, 16'h0000);
    check("R1 req idle", xfer_req, 0);

    // R2 R5 R7: single-mode write on slot 1, count 2
    wr(6'h01, 16'h1000); wr(6'h09, 16'h0002);
    rd(6'h09, v); check("R2 count readback", v, 16'h0002);
    wr(6'h12, 16'h0045); wr(6'h14, 16'h000D);
    expect_xfer(1, 16'h1000, 0, 0, 1);
    expect_xfer(1, 16'h1001, 0, 0, 1);
    expect_xfer(1, 16'h1002, 1, 0, 1);
    rises = 0; dreq[1] = 1;
    drain();
    check("R7 single grants", rises, 3);
    dreq[1] = 0;
    rd(6'h09, v); check("R5 count wraps", v, 16'hFFFF);
    rd(6'h01, v); check("R4 address stepped", v, 16'h1003);
    rd(6'h14, v); check("R5 mask set", v, 16'h000F);
    rd(6'h16, v); check("R5 status tc", v, 16'h0002);

    // R3 R13: slots 0 and 3 together; slot 0 has bit 5 set
    wr(6'h00, 16'h0010); wr(6'h08, 16'h0000); wr(6'h12, 16'h0064);
    wr(6'h03, 16'h0300); wr(6'h0B, 16'h0000); wr(6'h12, 16'h0047);
    wr(6'h14, 16'h0006);
    expect_xfer(0, 16'h0010, 1, 0, 1);
    expect_xfer(3, 16'h0300, 1, 0, 1);
    @(negedge clk); dreq[0] = 1; dreq[3] = 1;
    drain();
    dreq[0] = 0; dreq[3] = 0;
    rd(6'h00, v); check("R13 increments", v, 16'h0011);

    // R11: half disabled, other command bits ignored
    wr(6'h10, 16'h00FF);
    rd(6'h10, v); check("R11 command read", v, 16'h0004);
    wr(6'h02, 16'h0040); wr(6'h0A, 16'h0000); wr(6'h12, 16'h0042);
    wr(6'h14, 16'h000B);
    dreq[2] = 1;
    repeat (10) @(negedge clk);
    check("R11 disabled no req", xfer_req, 0);
    rd(6'h02, v); check("R11 address untouched", v, 16'h0040);
    rd_clear(6'h16);
    // R9 verify transfer, R12 clear and set in the same cycle
    expect_xfer(2, 16'h0040, 1, 0, 0);
    wr(6'h10, 16'h00FB);
    do @(negedge clk); while (!xfer_req);
    reg_addr = 6'h16; reg_re = 1;
    @(negedge clk); reg_re = 0;
    dreq[2] = 0;
    drain();
    rd(6'h16, v); check("R12 set wins over clear", v, 16'h0004);
    rd(6'h02, v); check("R9 verify steps address", v, 16'h0041);
    rd_clear(6'h16);
    rd(6'h16, v); check("R12 read clears", v, 16'h0000);

    // R8 R6: demand read, auto-init, slot 5 (wide)
    wr(6'h05, 16'h0200); wr(6'h0D, 16'h0001); wr(6'h13, 16'h0019);
    wr(6'h15, 16'h000D);
    expect_xfer(5, 16'h0200, 0, 1, 0);
    expect_xfer(5, 16'h0201, 1, 1, 0);
    expect_xfer(5, 16'h0200, 0, 1, 0);
    expect_xfer(5, 16'h0201, 1, 1, 0);
    rises = 0; dreq[5] = 1;
    wait (exp_q.size() == 0);
    dreq[5] = 0;
    repeat (4) @(negedge clk);
    check("R8 demand bursts", rises, 2);
    rd(6'h0D, v); check("R6 count reloaded", v, 16'h0001);
    rd(6'h05, v); check("R6 address reloaded", v, 16'h0200);
    rd(6'h15, v); check("R6 mask stays clear", v, 16'h000D);
    rd(6'h17, v); check("R5 status hi tc", v, 16'h0002);

    // R10: cascade slot never transfers
    wr(6'h04, 16'h0444); wr(6'h13, 16'h0040); wr(6'h15, 16'h000C);
    dreq[4] = 1;
    repeat (10) @(negedge clk);
    check("R10 cascade idle", xfer_req, 0);
    rd(6'h04, v); check("R10 address kept", v, 16'h0444);
    dreq[4] = 0;

    // R9: type 11 never requests
    wr(6'h06, 16'h0600); wr(6'h13, 16'h004E); wr(6'h15, 16'h0008);
    dreq[6] = 1;
    repeat (10) @(negedge clk);
    check("R9 illegal type idle", xfer_req, 0);
    rd(6'h06, v); check("R9 illegal address kept", v, 16'h0600);
    dreq[6] = 0;

    // R7: obsolete mode 10 acts as single
    wr(6'h07, 16'h0700); wr(6'h0F, 16'h0001); wr(6'h13, 16'h0087);
    wr(6'h15, 16'h0000);
    expect_xfer(7, 16'h0700, 0, 0, 1);
    expect_xfer(7, 16'h0701, 1, 0, 1);
    rises = 0; dreq[7] = 1;
    drain();
    check("R7 obsolete mode single", rises, 2);
    dreq[7] = 0;
    rd(6'h15, v); check("R5 slot 7 masked", v, 16'h0008);
    rd(6'h17, v); check("R5 status hi both", v, 16'h000A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule